// File: doc/BRIEF.md
# Serial Flash Instruction Frame Engine

This block is a single-master SPI engine that runs one complete serial-flash transaction for each request it accepts. A request names an 8-bit instruction and, optionally, a 24-bit address, a number of bytes to transmit and a number of bytes to receive. The engine lowers chip select, shifts the whole frame out on MOSI, captures MISO during the read part, and raises chip select again. Four frame shapes result: instruction alone (for example 0x06, write enable), instruction with address (0x20, sector erase), instruction with data, and instruction with address and data (0x03 followed by an address and then read bytes).

Clock polarity and clock phase are inputs captured with each request, so all four SPI modes are available frame by frame. The serial clock is a register driven from a half-period timer that divides the system clock by the even parameter `CLK_DIV`. Between frames it rests at the level that polarity selects.

On the user side, a one-cycle `start` launches a frame, `busy` covers it, and `done` marks its end. Transmit bytes are taken from `txData`, and `txReady` asks for the next one. Each received byte appears on `rxData` with a one-cycle `rxValid`.

Top module: `flash_frame_engine`

## Requirements
- R1: While no frame is active, `sclk` sits at the level of `cpol` (low for 0, high for 1), following a change of `cpol` within two cycles.
- R2: `csN` is low in one unbroken window per frame. Exactly `CLK_DIV/2` system cycles separate its fall from the first `sclk` transition, and the last transition from its rise.
- R3: MOSI carries the frame most significant bit first: the instruction, then address bits 23 down to 0 when `useAddr` is 1, then the `txCount` transmit bytes. Throughout the receive bytes it carries 0.
- R4: The capturing edge is the first transition of each bit when `cpha` is 0 and the second when `cpha` is 1. The outgoing bit changes only on the other transition, so modes {cpol,cpha} 00 and 11 capture on rising edges and modes 01 and 10 capture on falling edges.
- R5: Each frame makes exactly two `sclk` transitions per bit, for 8 + 24·useAddr + 8·(txCount + rxCount) bits in all.
- R6: With `cpha` 0, MOSI shows instruction bit 7 in the same cycle that `csN` goes low.
- R7: Each of the `rxCount` received bytes is assembled most significant bit first and presented on `rxData` with a one-cycle `rxValid` pulse, in order.
- R8: `txReady` pulses for one cycle after each transmit byte is taken from `txData`, so it pulses exactly `txCount` times per frame. The first byte must be on `txData` at `start`, and each following byte by the cycle after the pulse.
- R9: `busy` rises in the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle after `csN` rises, and `busy` falls with it.
- R10: A `start` that arrives while `busy` is high is ignored. The running frame keeps the instruction and settings captured at its own start, and no second frame follows.
- R11: All four frame shapes and the instruction-only case with no data phase run in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| cpol | input | 1 | Clock polarity for the next frame; also sets the idle level |
| cpha | input | 1 | Clock phase for the next frame |
| start | input | 1 | One-cycle frame request, taken only while idle |
| instr | input | 8 | Instruction byte |
| useAddr | input | 1 | Send the 24-bit address after the instruction |
| addr | input | 24 | Address |
| txCount | input | CNT_W | Number of bytes to transmit after the header |
| rxCount | input | CNT_W | Number of bytes to receive after the transmit bytes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| txData | input | 8 | Current transmit byte |
| txReady | output | 1 | Transmit byte taken; present the next one |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A slip in the byte pointer or in its phase sequencing shows at the ports within a single byte time. The wrong byte source or a shifted bit appears on MOSI and is caught by a slave model that samples on the mode's own capturing edge. An edge counter that is off by one changes the number of `sclk` transitions and moves the chip-select rise and the `done` pulse, and both are visible at the end of the frame. A wrong edge-parity or receive-window decision corrupts the received bytes or the count of `rxValid` pulses, so every frame checks its received bytes against the slave's known stream in all four modes.

// File: rtl/flash_frame_pkg.sv
package flash_frame_pkg;

  localparam int ADDR_W = 24;

  // Where the next outgoing byte comes from
  typedef enum logic [2:0] {
    SRC_INSTR,
    SRC_ADDR_HI,
    SRC_ADDR_MID,
    SRC_ADDR_LO,
    SRC_TX,
    SRC_ZERO
  } byteSrc_e;

  // Frame section the outgoing pointer is in
  typedef enum logic [1:0] {
    PH_INSTR,
    PH_ADDR,
    PH_TX,
    PH_RX
  } phase_e;

  // Control-to-datapath strobes, valid for one system cycle
  typedef struct packed {
    logic     capture;     // request accepted: latch operands, park clock
    logic     launch;      // drive the next outgoing bit
    logic     loadByte;    // the launched bit is bit 7 of a fresh byte
    byteSrc_e src;         // source of that fresh byte
    logic     sample;      // capturing clock edge now
    logic     rxActive;    // the captured bit belongs to the read section
    logic     sclkToggle;  // serial clock transition now
    logic     sclkIdle;    // no frame: hold clock at polarity level
  } strobes_t;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import flash_frame_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cpha,
  input  logic             useAddr,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output strobes_t         st,
  output logic             busy,
  output logic             done,
  output logic             csN
);

  localparam int HALF   = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int TMR_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGE_W = CNT_W + 7;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TRAIL, S_DONE} state_e;

  state_e             state;
  logic [TMR_W-1:0]   tmr;
  logic [EDGE_W-1:0]  edgesLeft;
  logic [EDGE_W-1:0]  rxBits;
  logic               cfgCpha;
  logic               cfgUseAddr;
  logic [CNT_W-1:0]   cfgTxCount;
  phase_e             ptrPhase;
  logic [CNT_W-1:0]   ptrByte;
  logic [2:0]         ptrBit;

  logic               accept;
  logic               tick;
  logic               edgeNow;
  logic               lead;
  logic               lastEdge;
  logic               launchNow;
  logic               sampleNow;
  logic [EDGE_W-1:0]  totBits;
  logic [EDGE_W-1:0]  remBits;
  phase_e             curPhase;
  logic [CNT_W-1:0]   curByte;
  logic [2:0]         curBit;
  phase_e             nPhase;
  logic [CNT_W-1:0]   nByte;
  logic [2:0]         nBit;
  byteSrc_e           srcSel;

  assign accept   = (state == S_IDLE) && start;
  assign tick     = (tmr == TMR_W'(HALF - 1));
  assign edgeNow  = (state == S_SHIFT) && tick;
  assign lead     = ~edgesLeft[0];
  assign lastEdge = (edgesLeft == EDGE_W'(1));
  assign busy     = (state != S_IDLE);

  assign totBits = EDGE_W'(8) + (useAddr ? EDGE_W'(24) : '0)
                 + ((EDGE_W'(txCount) + EDGE_W'(rxCount)) << 3);
  assign remBits = (edgesLeft + EDGE_W'(1)) >> 1;

  // Launch edge: leading when cpha=1, trailing (except the very last) when cpha=0
  assign launchNow = accept ? ~cpha
                   : edgeNow && (cfgCpha ? lead : (~lead && ~lastEdge));
  assign sampleNow = edgeNow && (cfgCpha ? ~lead : lead);

  assign curPhase = accept ? PH_INSTR : ptrPhase;
  assign curByte  = accept ? '0 : ptrByte;
  assign curBit   = accept ? 3'd0 : ptrBit;

  always_comb begin
    nPhase = curPhase;
    nByte  = curByte;
    nBit   = curBit + 3'd1;
    if (curBit == 3'd7) begin
      nByte = '0;
      case (curPhase)
        PH_INSTR: nPhase = cfgUseAddr ? PH_ADDR
                         : ((cfgTxCount != '0) ? PH_TX : PH_RX);
        PH_ADDR:
          if (curByte == CNT_W'(2)) nPhase = (cfgTxCount != '0) ? PH_TX : PH_RX;
          else                      nByte  = curByte + CNT_W'(1);
        PH_TX:
          if (curByte == cfgTxCount - CNT_W'(1)) nPhase = PH_RX;
          else                                   nByte  = curByte + CNT_W'(1);
        default: nPhase = PH_RX;
      endcase
    end
  end

  always_comb begin
    case (curPhase)
      PH_INSTR: srcSel = SRC_INSTR;
      PH_ADDR:  srcSel = (curByte == '0) ? SRC_ADDR_HI
                       : ((curByte == CNT_W'(1)) ? SRC_ADDR_MID : SRC_ADDR_LO);
      PH_TX:    srcSel = SRC_TX;
      default:  srcSel = SRC_ZERO;
    endcase
  end

  always_comb begin
    st.capture    = accept;
    st.launch     = launchNow;
    st.loadByte   = (curBit == 3'd0);
    st.src        = srcSel;
    st.sample     = sampleNow;
    st.rxActive   = (remBits <= rxBits);
    st.sclkToggle = edgeNow;
    st.sclkIdle   = (state == S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      tmr        <= '0;
      edgesLeft  <= '0;
      rxBits     <= '0;
      cfgCpha    <= 1'b0;
      cfgUseAddr <= 1'b0;
      cfgTxCount <= '0;
      ptrPhase   <= PH_INSTR;
      ptrByte    <= '0;
      ptrBit     <= 3'd0;
      csN        <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launchNow) begin
        ptrPhase <= nPhase;
        ptrByte  <= nByte;
        ptrBit   <= nBit;
      end else if (accept) begin
        ptrPhase <= PH_INSTR;
        ptrByte  <= '0;
        ptrBit   <= 3'd0;
      end
      case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_SHIFT;
            tmr        <= '0;
            edgesLeft  <= totBits << 1;
            rxBits     <= EDGE_W'(rxCount) << 3;
            cfgCpha    <= cpha;
            cfgUseAddr <= useAddr;
            cfgTxCount <= txCount;
            csN        <= 1'b0;
          end
        end
        S_SHIFT: begin
          tmr <= tick ? '0 : tmr + TMR_W'(1);
          if (tick) begin
            edgesLeft <= edgesLeft - EDGE_W'(1);
            if (lastEdge) state <= S_TRAIL;
          end
        end
        S_TRAIL: begin
          tmr <= tick ? '0 : tmr + TMR_W'(1);
          if (tick) begin
            state <= S_DONE;
            csN   <= 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import flash_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic              cpol,
  input  logic [7:0]        instr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        txData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              txReady,
  output logic [7:0]        rxData,
  output logic              rxValid
);

  logic [7:0]        instrR;
  logic [ADDR_W-1:0] addrR;
  logic [7:0]        shiftOut;
  logic [6:0]        rxShift;
  logic [2:0]        rxCnt;
  logic [7:0]        byteIn;

  always_comb begin
    case (st.src)
      SRC_INSTR:    byteIn = st.capture ? instr : instrR;
      SRC_ADDR_HI:  byteIn = addrR[23:16];
      SRC_ADDR_MID: byteIn = addrR[15:8];
      SRC_ADDR_LO:  byteIn = addrR[7:0];
      SRC_TX:       byteIn = txData;
      default:      byteIn = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrR   <= '0;
      addrR    <= '0;
      shiftOut <= '0;
      rxShift  <= '0;
      rxCnt    <= 3'd0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      txReady  <= 1'b0;
      mosi     <= 1'b0;
      sclk     <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      txReady <= st.launch && st.loadByte && (st.src == SRC_TX);
      if (st.capture) begin
        instrR <= instr;
        addrR  <= addr;
        rxCnt  <= 3'd0;
      end
      if (st.launch) begin
        if (st.loadByte) begin
          mosi     <= byteIn[7];
          shiftOut <= {byteIn[6:0], 1'b0};
        end else begin
          mosi     <= shiftOut[7];
          shiftOut <= {shiftOut[6:0], 1'b0};
        end
      end
      if (st.sample && st.rxActive) begin
        rxShift <= {rxShift[5:0], miso};
        rxCnt   <= rxCnt + 3'd1;
        if (rxCnt == 3'd7) begin
          rxData  <= {rxShift, miso};
          rxValid <= 1'b1;
        end
      end
      if (st.capture)         sclk <= cpol;
      else if (st.sclkToggle) sclk <= ~sclk;
      else if (st.sclkIdle)   sclk <= cpol;
    end
  end

endmodule

// File: rtl/flash_frame_engine.sv
module flash_frame_engine
  import flash_frame_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [7:0]        instr,
  input  logic              useAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  output logic              busy,
  output logic              done,
  input  logic [7:0]        txData,
  output logic              txReady,
  output logic [7:0]        rxData,
  output logic              rxValid,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  strobes_t st;

  frame_ctrl #(
    .CLK_DIV (CLK_DIV),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cpha    (cpha),
    .useAddr (useAddr),
    .txCount (txCount),
    .rxCount (rxCount),
    .st      (st),
    .busy    (busy),
    .done    (done),
    .csN     (csN)
  );

  frame_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .cpol    (cpol),
    .instr   (instr),
    .addr    (addr),
    .txData  (txData),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .txReady (txReady),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: rtl/flash_frame_checker.sv
module flash_frame_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic cpol,
  input logic busy,
  input logic done,
  input logic csN,
  input logic sclk,
  input logic rxValid,
  input logic txReady
);

  // R1: idle clock follows polarity
  assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !busy && !$past(busy)) |-> (sclk == $past(cpol)));

  // R2: chip select only inside a frame
  assert_cs_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R9: done one cycle after chip-select release
  assert_done_after_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> done);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: receive strobe is a single-cycle pulse
  assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8: transmit request only while selected, one cycle wide
  assert_tx_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !csN);
  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);

  // R10: a frame only begins after a start request
  assert_start_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind flash_frame_engine flash_frame_checker u_chk (.*);

// File: tb/flash_frame_engine_tb.sv
`timescale 1ns/1ps
module flash_frame_engine_tb;

  localparam int CLK_DIV = 4;
  localparam int CNT_W   = 5;
  localparam int HALF    = CLK_DIV / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cpol = 1'b0;
  logic             cpha = 1'b0;
  logic             start = 1'b0;
  logic [7:0]       instr = 8'h00;
  logic             useAddr = 1'b0;
  logic [23:0]      addr = '0;
  logic [CNT_W-1:0] txCount = '0;
  logic [CNT_W-1:0] rxCount = '0;
  logic             busy, done, txReady, rxValid, csN, sclk, mosi;
  logic [7:0]       txData = 8'h00;
  logic [7:0]       rxData;
  logic             miso = 1'b0;

  always #10 clk = ~clk;

  flash_frame_engine #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .start(start),
    .instr(instr), .useAddr(useAddr), .addr(addr), .txCount(txCount),
    .rxCount(rxCount), .busy(busy), .done(done), .txData(txData),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .csN(csN),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  // ---------------- slave model and monitor ----------------
  int        frameSeed = 0;
  bit        modeCpha = 0;
  bit        prevSclk = 0;
  bit        prevCs = 1;
  int        edgeCnt, nSampled, misoIdx;
  int        csFallCyc, csRiseCyc, firstEdgeCyc, lastEdgeCyc, doneCyc;
  bit        csFallMosi;
  logic [7:0] mosiBytes [0:63];
  logic [7:0] rxGot [0:63];
  int        nRx, txIdx;

  function automatic logic [7:0] slaveByte(input int k);
    return 8'((k * 53 + 90) ^ (frameSeed * 7));
  endfunction

  function automatic logic [7:0] txPattern(input int k);
    return 8'(k * 29 + 49 + frameSeed * 11);
  endfunction

  function automatic bit streamBit(input int i);
    logic [7:0] b;
    b = slaveByte(i / 8);
    return b[7 - (i % 8)];
  endfunction

  always @(negedge clk) begin
    if (prevCs && !csN) begin
      csFallCyc  = cyc;
      csFallMosi = mosi;
      edgeCnt    = 0;
      nSampled   = 0;
      if (!modeCpha) begin
        miso    = streamBit(0);
        misoIdx = 1;
      end else begin
        misoIdx = 0;
      end
    end else if (!csN && (sclk != prevSclk)) begin
      edgeCnt++;
      if (edgeCnt == 1) firstEdgeCyc = cyc;
      lastEdgeCyc = cyc;
      if ((edgeCnt % 2 == 1) != modeCpha) begin
        if (nSampled < 512) mosiBytes[nSampled / 8][7 - (nSampled % 8)] = mosi;
        nSampled++;
      end else begin
        miso = streamBit(misoIdx);
        misoIdx++;
      end
    end
    if (csN && !prevCs) csRiseCyc = cyc;
    if (done) doneCyc = cyc;
    if (rxValid) begin
      if (nRx < 64) rxGot[nRx] = rxData;
      nRx++;
    end
    if (txReady) begin
      txIdx++;
      txData = txPattern(txIdx);
    end
    prevSclk = sclk;
    prevCs   = csN;
  end

  // ---------------- frame driver ----------------
  task automatic runFrame(input int m, input int s);
    logic [7:0]  expInstr;
    bit          expUseA;
    logic [23:0] expAddr;
    int          ntx, nrx, hdr, bits, guard;
    bit          quietOk;
    logic [7:0]  expByte;

    case (s)
      0: begin expInstr = 8'h06; expUseA = 0; ntx = 0; nrx = 0; end
      1: begin expInstr = 8'h20; expUseA = 1; ntx = 0; nrx = 0; end
      2: begin expInstr = 8'h03; expUseA = 1; ntx = 0; nrx = 3; end
      3: begin expInstr = 8'hA7; expUseA = 0; ntx = 2; nrx = 0; end
      4: begin expInstr = 8'h0B; expUseA = 1; ntx = 1; nrx = 2; end
      default: begin expInstr = 8'h05; expUseA = 0; ntx = 0; nrx = 1; end
    endcase
    expAddr = 24'h5AC31E ^ 24'(frameSeed * 24'h010307);
    hdr  = expUseA ? 4 : 1;
    bits = 8 * (hdr + ntx + nrx);

    cpol = m[1]; cpha = m[0]; modeCpha = m[0];
    instr = expInstr; useAddr = expUseA; addr = expAddr;
    txCount = CNT_W'(ntx); rxCount = CNT_W'(nrx);
    txIdx = 0; nRx = 0; doneCyc = -1;
    txData = txPattern(0);

    repeat (3) @(negedge clk);
    chk(sclk == cpol, "R1 idle level", sclk, cpol);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && csN == 1'b0, "R9 busy/select after start", {busy, csN}, 2'b10);
    if (!m[0]) chk(mosi == expInstr[7], "R6 first bit at select", mosi, expInstr[7]);

    // R10: second request during the frame, with a different instruction
    repeat (4) @(negedge clk);
    instr = ~expInstr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    guard = 0;
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);

    chk(edgeCnt == 2 * bits, "R5 clock transitions", edgeCnt, 2 * bits);
    chk(firstEdgeCyc - csFallCyc == HALF, "R2 lead gap", firstEdgeCyc - csFallCyc, HALF);
    chk(csRiseCyc - lastEdgeCyc == HALF, "R2 trail gap", csRiseCyc - lastEdgeCyc, HALF);
    chk(doneCyc - csRiseCyc == 1, "R9 done after release", doneCyc - csRiseCyc, 1);
    chk(busy == 1'b0, "R9 busy low after done", busy, 0);

    for (int k = 0; k < hdr + ntx + nrx; k++) begin
      if (k == 0)                     expByte = expInstr;
      else if (k < hdr)               expByte = expAddr[(3 - k) * 8 +: 8];
      else if (k < hdr + ntx)         expByte = txPattern(k - hdr);
      else                            expByte = 8'h00;
      chk(mosiBytes[k] == expByte, "R3 R4 R10 R11 mosi byte", mosiBytes[k], expByte);
    end

    chk(txIdx == ntx, "R8 transmit requests", txIdx, ntx);
    chk(nRx == nrx, "R7 receive strobes", nRx, nrx);
    for (int j = 0; j < nrx && j < 64; j++)
      chk(rxGot[j] == slaveByte(hdr + ntx + j), "R4 R7 received byte",
          rxGot[j], slaveByte(hdr + ntx + j));

    quietOk = 1;
    for (int q = 0; q < 12; q++) begin
      @(negedge clk);
      if (!csN || busy) quietOk = 0;
    end
    chk(quietOk, "R10 no second frame", quietOk, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && busy == 1'b0 && done == 1'b0 && rxValid == 1'b0 && txReady == 1'b0,
        "R2 R9 reset state", {csN, busy, done, rxValid, txReady}, 5'b10000);
    chk(sclk == 1'b0, "R1 reset idle level", sclk, 0);

    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R1 follows polarity high", sclk, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R1 follows polarity low", sclk, 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 6; s++) begin
        frameSeed = m * 6 + s + 1;
        runFrame(m, s);
      end
    end
    finishRun();
  end

endmodule